// File: doc/BRIEF.md
# Watchdog Timer with Paired-Clear

This block guards a processor against runaway code. It counts ticks from one of two sources: a dedicated slow oscillator, which arrives as a one-cycle enable pulse in the system clock domain, or the system clock divided by four. The ticks feed a 6-bit prescaler and then a single clearable bit. When that last bit overflows, the block signals a time-out. If the processor is running, the time-out becomes a full device reset. If the processor is powered down, it becomes a partial reset of the program counter and stack only. In both cases a sticky status flag is set.

Software keeps the timer from expiring by sending decoded clear strobes. A software clear resets only the last stage and leaves the prescaler's residual count in place, so the time-out after a clear can be anywhere from 65 to 128 ticks. A mode select picks the clear scheme. In single-clear mode, one strobe is enough. In paired-clear mode, a clear happens only when a strobe arrives whose type differs from the type of the previous strobe. A halt strobe clears the whole chain. The external reset clears everything, including the status flag.

There is no data stream through this block. Every pin is a plain control or status signal with no handshake, so back-pressure does not apply.

Top module: `wdt_paired_clear`

## Requirements
- R1: The tick source is chosen by `src_sel`. When `src_sel`=0, each cycle with `osc_tick`=1 is one tick. When `src_sel`=1, there is one tick every 4 system clocks and `osc_tick` is ignored. Ticks count only while `cfg_present`=1 and `run_en`=1.
- R2: After the external reset, a time-out occurs on the 128th tick: 64 ticks fill the prescaler, then 64 more overflow the last stage. With the sys/4 source, time-outs repeat every 512 clocks.
- R3: A software clear resets only the last stage. If the prescaler holds residual value p when the clear is taken, the next time-out comes 128-p ticks later.
- R4: In single-clear mode (`clr_mode`=0), a `clr_single` strobe performs a clear, and `clr_first` and `clr_second` have no effect.
- R5: In paired-clear mode (`clr_mode`=1), a `clr_first` or `clr_second` strobe clears only if the previous strobe was of the other type. The first strobe after reset never clears. Repeating the same type has no effect. A cycle with both strobes high is ignored. `clr_single` has no effect.
- R6: A `halt` strobe clears both the prescaler and the last stage, so the next time-out comes 128 ticks later.
- R7: While `cfg_present`=0, no time-out occurs, the chain holds its value, and the clear and halt strobes have no effect.
- R8: While `run_en`=0 (with `cfg_present`=1), the chain holds its value, but clear strobes still act.
- R9: A time-out with `power_down`=0 pulses `dev_rst` high for exactly one clock, starting one clock after the tick that overflows. With `power_down`=1, the pulse goes to `part_rst` instead. The two pulses never occur together.
- R10: `to_flag` is set by every time-out and stays set. Clears and halt do not change it.
- R11: `ext_rst_n`=0 clears the prescaler, the last stage, the paired-clear history and `to_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| cfg_present | input | 1 | Configuration-level watchdog enable |
| src_sel | input | 1 | Tick source: 0 oscillator pulse, 1 system clock / 4 |
| clr_mode | input | 1 | Clear scheme: 0 single, 1 paired |
| run_en | input | 1 | Runtime enable bit |
| osc_tick | input | 1 | One-cycle pulse from the dedicated oscillator |
| clr_single | input | 1 | Decoded single-clear strobe |
| clr_first | input | 1 | Decoded first-type paired strobe |
| clr_second | input | 1 | Decoded second-type paired strobe |
| halt | input | 1 | Decoded halt strobe |
| power_down | input | 1 | Processor is in power-down mode |
| dev_rst | output | 1 | Full device reset pulse |
| part_rst | output | 1 | Partial reset pulse (program counter and stack) |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The hardest state to reach from the ports is a software clear taken with a known residual in the prescaler and the last stage already set. The internals are hidden, so the bench gets there by counting: after reset it sends exactly 64+p oscillator ticks, applies the strobes under test, and then counts ticks until the reset pulse. A count of 128-p shows that a clear was taken. A count of 64-p shows that no clear happened. The bench sweeps every residual from 0 to 63 and every paired-strobe ordering it uses. The same counting method shows that the chain stays frozen across disabled periods.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // last paired-clear strobe type seen
  typedef enum logic [1:0] {
    PAIR_NONE   = 2'd0,
    PAIR_FIRST  = 2'd1,
    PAIR_SECOND = 2'd2
  } pair_last_e;

  localparam int PRESCALE_W_DEF = 6;
  localparam int SYSDIV_W_DEF   = 2;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int SYSDIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic src_sel,
  input  logic osc_tick,
  output logic tick
);
  logic sys_tick;

  generate
    if (SYSDIV_W == 0) begin : g_nodiv
      assign sys_tick = enable;
    end else begin : g_div
      localparam logic [SYSDIV_W-1:0] DIV_LAST = '1;
      logic [SYSDIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (enable) div_q <= div_q + 1'b1;
      end
      assign sys_tick = enable && (div_q == DIV_LAST);
    end
  endgenerate

  always_comb begin
    if (!enable)      tick = 1'b0;
    else if (src_sel) tick = sys_tick;
    else              tick = osc_tick;
  end
endmodule

// File: rtl/wdt_clear_ctrl.sv
module wdt_clear_ctrl
  import wdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clr_mode,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  output logic soft_clear
);
  pair_last_e last_q, last_d;
  logic       pair_hit;

  always_comb begin
    last_d   = last_q;
    pair_hit = 1'b0;
    if (enable && clr_mode && (clr_first ^ clr_second)) begin
      if (clr_first) begin
        pair_hit = (last_q == PAIR_SECOND);
        last_d   = PAIR_FIRST;
      end else begin
        pair_hit = (last_q == PAIR_FIRST);
        last_d   = PAIR_SECOND;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= PAIR_NONE;
    else        last_q <= last_d;
  end

  assign soft_clear = enable && (clr_mode ? pair_hit : clr_single);
endmodule

// File: rtl/wdt_div_chain.sv
module wdt_div_chain #(
  parameter int PRESCALE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic soft_clear,
  input  logic full_clear,
  output logic overflow
);
  localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;

  logic [PRESCALE_W-1:0] pre_q;
  logic                  last_q;
  logic                  pre_wrap;

  assign pre_wrap = tick && (pre_q == PRE_MAX);
  assign overflow = pre_wrap && last_q && !soft_clear && !full_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      last_q <= 1'b0;
    end else if (full_clear) begin
      pre_q  <= '0;
      last_q <= 1'b0;
    end else begin
      if (tick) pre_q <= pre_q + 1'b1;
      if (soft_clear)    last_q <= 1'b0;
      else if (pre_wrap) last_q <= ~last_q;
    end
  end
endmodule

// File: rtl/wdt_paired_clear.sv
module wdt_paired_clear #(
  parameter int PRESCALE_W = wdt_pkg::PRESCALE_W_DEF,
  parameter int SYSDIV_W   = wdt_pkg::SYSDIV_W_DEF
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic cfg_present,
  input  logic src_sel,
  input  logic clr_mode,
  input  logic run_en,
  input  logic osc_tick,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  input  logic halt,
  input  logic power_down,
  output logic dev_rst,
  output logic part_rst,
  output logic to_flag
);
  logic tick, soft_clear, full_clear, overflow;
  logic dev_q, part_q, flag_q;

  wdt_tick_gen #(.SYSDIV_W(SYSDIV_W)) u_tick (
    .clk(clk), .rst_n(ext_rst_n), .enable(cfg_present && run_en),
    .src_sel(src_sel), .osc_tick(osc_tick), .tick(tick)
  );

  wdt_clear_ctrl u_clr (
    .clk(clk), .rst_n(ext_rst_n), .enable(cfg_present), .clr_mode(clr_mode),
    .clr_single(clr_single), .clr_first(clr_first), .clr_second(clr_second),
    .soft_clear(soft_clear)
  );

  assign full_clear = cfg_present && halt;

  wdt_div_chain #(.PRESCALE_W(PRESCALE_W)) u_chain (
    .clk(clk), .rst_n(ext_rst_n), .tick(tick), .soft_clear(soft_clear),
    .full_clear(full_clear), .overflow(overflow)
  );

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      dev_q  <= 1'b0;
      part_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      dev_q  <= overflow && !power_down;
      part_q <= overflow && power_down;
      if (overflow) flag_q <= 1'b1;
    end
  end

  assign dev_rst  = dev_q;
  assign part_rst = part_q;
  assign to_flag  = flag_q;
endmodule

// File: rtl/wdt_paired_clear_chk.sv
module wdt_paired_clear_chk (
  input logic clk,
  input logic ext_rst_n,
  input logic cfg_present,
  input logic power_down,
  input logic dev_rst,
  input logic part_rst,
  input logic to_flag
);
  assert_resets_exclusive_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !(dev_rst && part_rst));
  assert_dev_single_cycle_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    dev_rst |=> !dev_rst);
  assert_part_single_cycle_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    part_rst |=> !part_rst);
  assert_dev_not_in_powerdown_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    dev_rst |-> !$past(power_down));
  assert_part_only_in_powerdown_R9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    part_rst |-> $past(power_down));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    to_flag |=> to_flag);
  assert_flag_with_reset_R10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (dev_rst || part_rst) |-> to_flag);
  assert_quiet_when_absent_R7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !$past(cfg_present) |-> !(dev_rst || part_rst));
endmodule

bind wdt_paired_clear wdt_paired_clear_chk u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .cfg_present(cfg_present),
  .power_down(power_down), .dev_rst(dev_rst), .part_rst(part_rst),
  .to_flag(to_flag)
);

// File: tb/tb_wdt_paired_clear.sv
module tb_wdt_paired_clear;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic cfg_present = 1'b1, src_sel = 1'b0, clr_mode = 1'b0, run_en = 1'b1;
  logic osc_tick = 1'b0, clr_single = 1'b0, clr_first = 1'b0, clr_second = 1'b0;
  logic halt = 1'b0, power_down = 1'b0;
  logic dev_rst, part_rst, to_flag;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdt_paired_clear dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) ext_rst_n = 1'b0;
    @(negedge clk) ext_rst_n = 1'b1;
  endtask

  task automatic do_tick();
    @(negedge clk) osc_tick = 1'b1;
    @(negedge clk) osc_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) do_tick();
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: clr_single = 1'b1;
      1: clr_first = 1'b1;
      2: clr_second = 1'b1;
      3: begin clr_first = 1'b1; clr_second = 1'b1; end
      default: halt = 1'b1;
    endcase
    @(negedge clk);
    clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt = 1'b0;
  endtask

  // ticks until a reset pulse; -1 if none within limit
  task automatic run_to(output int n, output bit was_part);
    int k = 0;
    bit done = 0;
    was_part = 0;
    while (!done && k < 300) begin
      do_tick();
      k++;
      if (dev_rst || part_rst) begin done = 1; was_part = part_rst; end
    end
    n = done ? k : -1;
  endtask

  // reset, load residual p with last stage set, run sequence, measure
  task automatic scen(input bit mode, input int s0, input int s1, input bit cleared,
                      input int p, input string req);
    int n; bit wp;
    clr_mode = mode;
    do_reset();
    ticks(64 + p);
    if (s0 >= 0) strobe(s0);
    if (s1 >= 0) strobe(s1);
    run_to(n, wp);
    chk(n == (cleared ? 128 - p : 64 - p), req, n, cleared ? 128 - p : 64 - p);
  endtask

  initial begin
    int n, c0, c1;
    bit wp;
    do_reset();
    @(negedge clk);
    chk(!dev_rst && !part_rst && !to_flag, "R11 reset state", {dev_rst, part_rst, to_flag}, 0);

    run_to(n, wp);
    chk(n == 128, "R2 first timeout", n, 128);
    chk(!wp, "R9 dev_rst not part_rst", wp, 0);
    @(negedge clk);
    chk(!dev_rst, "R9 single-cycle pulse", dev_rst, 0);
    chk(to_flag, "R10 flag set", to_flag, 1);
    strobe(0); strobe(4);
    chk(to_flag, "R10 flag kept after clears", to_flag, 1);

    for (int p = 0; p < 64; p++) scen(1'b0, 0, -1, 1'b1, p, "R3 residual sweep");

    scen(1'b0, 1, 2, 1'b0, 5, "R4 paired strobes ignored");
    scen(1'b1, 1, -1, 1'b0, 5, "R5 first strobe no clear");
    scen(1'b1, 1, 1, 1'b0, 5, "R5 repeat same type");
    scen(1'b1, 1, 2, 1'b1, 5, "R5 first then second");
    scen(1'b1, 2, 1, 1'b1, 9, "R5 second then first");
    scen(1'b1, 1, 3, 1'b0, 5, "R5 both at once ignored");
    scen(1'b1, 0, -1, 1'b0, 5, "R5 single strobe ignored");

    clr_mode = 1'b1;
    do_reset(); ticks(64 + 5); strobe(1); strobe(2); ticks(64); strobe(2);
    run_to(n, wp);
    chk(n == 59, "R5 same type after completed clear", n, 59);
    do_reset(); ticks(64 + 5); strobe(1); strobe(2); ticks(64); strobe(1);
    run_to(n, wp);
    chk(n == 123, "R5 opposite type after completed clear", n, 123);
    do_reset(); strobe(1); do_reset(); ticks(64 + 5); strobe(2);
    run_to(n, wp);
    chk(n == 59, "R11 reset clears pair history", n, 59);
    clr_mode = 1'b0;

    do_reset(); ticks(64 + 20); strobe(4);
    run_to(n, wp);
    chk(n == 128, "R6 halt clears whole chain", n, 128);

    do_reset(); ticks(64 + 10); cfg_present = 1'b0;
    strobe(0); strobe(4);
    c0 = 0;
    for (int i = 0; i < 200; i++) begin do_tick(); if (dev_rst || part_rst) c0++; end
    chk(c0 == 0, "R7 no timeout when absent", c0, 0);
    cfg_present = 1'b1;
    run_to(n, wp);
    chk(n == 54, "R7 chain frozen, strobes ignored", n, 54);

    do_reset(); ticks(64 + 10); run_en = 1'b0;
    ticks(200); strobe(0); run_en = 1'b1;
    run_to(n, wp);
    chk(n == 118, "R8 frozen yet clear acts", n, 118);

    do_reset(); power_down = 1'b1;
    run_to(n, wp);
    chk(n == 128 && wp, "R9 power-down gives part_rst", n, 128);
    chk(to_flag, "R10 flag on partial reset", to_flag, 1);
    power_down = 1'b0;
    do_reset();
    chk(!to_flag, "R11 reset clears flag", to_flag, 0);

    src_sel = 1'b1; do_reset();
    c0 = -1; c1 = -1;
    for (int i = 0; i < 1200 && c1 < 0; i++) begin
      @(negedge clk);
      osc_tick = 1'b1;
      if (dev_rst) begin if (c0 < 0) c0 = i; else c1 = i; end
    end
    osc_tick = 1'b0;
    chk(c1 - c0 == 512, "R1 R2 sys/4 period", c1 - c0, 512);
    src_sel = 1'b0; do_reset();
    c0 = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (dev_rst) c0++; end
    chk(c0 == 0, "R1 no osc pulses no ticks", c0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule